// File: doc/BRIEF.md
# Predicated Compare-and-Execute Unit

This block is a single-issue integer execution slice that holds its own general register file and a file of one-bit predicate registers. Every operation that enters the issue port names a guard predicate. An operation whose guard reads 1 commits its result. An operation whose guard reads 0 still uses its issue slot and retires, but it changes no architectural state. Unguarded code names predicate 0, which always reads 1.

Compare operations evaluate a relational condition on two general registers and write the result into predicate registers. The dual form writes the result to one predicate and its complement to a second predicate in the same operation. A compiler can therefore replace a two-way branch with one dual compare and two complementary guarded moves. Side ports let an environment load and inspect both register files. A retire strobe with a squash flag reports each issued operation one cycle later.

Top module: `pred_exec_unit`

## Requirements
- R1: Predicate 0 always reads 1. A write aimed at predicate 0, from the side port or from a compare, is ignored.
- R2: After reset every predicate other than predicate 0 reads 0, and every general register reads 0.
- R3: An issued operation whose guard reads 1 writes its result to `issue_dst`, readable from the cycle after the issuing edge. The opcode encodings are 0 add, 1 subtract (src1-src2), 2 and, 3 or, 4 xor and 5 move (copies src1). Arithmetic wraps modulo 2^XLEN.
- R4: An issued operation whose guard reads 0 leaves every general register and every predicate unchanged.
- R5: Opcode 6 is a single compare. It writes the condition result to predicate `issue_pd1`. The condition encodings are 0 eq, 1 ne, 2 signed lt, 3 signed le, 4 signed gt, 5 signed ge, 6 unsigned lt and 7 unsigned ge, each evaluated as src1 op src2.
- R6: Opcode 7 is a dual compare. It writes the condition result to `issue_pd1` and its complement to `issue_pd2` in the same cycle. If both indices are equal, the complement wins.
- R7: A compare whose guard reads 0 writes neither destination predicate.
- R8: Each issue produces `retire_valid` high for exactly the following cycle. `retire_squashed` is high in that cycle exactly when the guard read 0.
- R9: The side write ports update their register from the next cycle. If an executing operation targets the same register in the same cycle, the operation's result wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | An operation is issued this cycle |
| issue_op | input | 3 | Opcode |
| issue_cond | input | 3 | Compare condition |
| issue_dst | input | log2(NGPR) | Destination general register |
| issue_src1 | input | log2(NGPR) | First source register |
| issue_src2 | input | log2(NGPR) | Second source register |
| issue_guard | input | log2(NPRED) | Guard predicate index |
| issue_pd1 | input | log2(NPRED) | Compare destination predicate (true) |
| issue_pd2 | input | log2(NPRED) | Dual compare destination predicate (complement) |
| gpr_wr_en | input | 1 | Side write enable for a general register |
| gpr_wr_addr | input | log2(NGPR) | Side write register index |
| gpr_wr_data | input | XLEN | Side write data |
| gpr_rd_addr | input | log2(NGPR) | Side read register index |
| gpr_rd_data | output | XLEN | Side read data |
| pred_wr_en | input | 1 | Side write enable for a predicate |
| pred_wr_idx | input | log2(NPRED) | Side write predicate index |
| pred_wr_val | input | 1 | Side write predicate value |
| pred_rd_idx | input | log2(NPRED) | Side read predicate index |
| pred_rd_val | output | 1 | Side read predicate value |
| retire_valid | output | 1 | An operation retired |
| retire_squashed | output | 1 | The retired operation was predicated off |

## Verification
Several properties hold on every cycle and are checked as such. Predicate 0 stays at 1. The retire strobe follows each issue by one cycle, with the squash flag set to the inverted guard. A predicated-off operation leaves both register files untouched when no side write occurs. A dual compare to two distinct writable predicates leaves them holding opposite values. The bench scenarios cover what a per-cycle property cannot show: the result value of each opcode, the truth table of every condition at the signed and unsigned boundaries, the two guarded moves that complete an if-conversion, and which writer wins when the side port and an operation target the same register.

// File: rtl/pred_exec_unit.sv
module pred_exec_unit #(
  parameter int XLEN  = 16,
  parameter int NGPR  = 8,
  parameter int NPRED = 16,
  localparam int GW = $clog2(NGPR),
  localparam int PW = $clog2(NPRED)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_valid,
  input  logic [2:0]      issue_op,
  input  logic [2:0]      issue_cond,
  input  logic [GW-1:0]   issue_dst,
  input  logic [GW-1:0]   issue_src1,
  input  logic [GW-1:0]   issue_src2,
  input  logic [PW-1:0]   issue_guard,
  input  logic [PW-1:0]   issue_pd1,
  input  logic [PW-1:0]   issue_pd2,
  input  logic            gpr_wr_en,
  input  logic [GW-1:0]   gpr_wr_addr,
  input  logic [XLEN-1:0] gpr_wr_data,
  input  logic [GW-1:0]   gpr_rd_addr,
  output logic [XLEN-1:0] gpr_rd_data,
  input  logic            pred_wr_en,
  input  logic [PW-1:0]   pred_wr_idx,
  input  logic            pred_wr_val,
  input  logic [PW-1:0]   pred_rd_idx,
  output logic            pred_rd_val,
  output logic            retire_valid,
  output logic            retire_squashed
);
  logic [NGPR-1:0][XLEN-1:0] gpr_q;
  logic [NPRED-1:0]          pred_q;
  logic [XLEN-1:0]           alu_res;
  logic                      cond_res;

  wire [XLEN-1:0] opa    = gpr_q[issue_src1];
  wire [XLEN-1:0] opb    = gpr_q[issue_src2];
  wire            guard  = pred_q[issue_guard];
  wire            is_cmp = issue_op[2:1] == 2'b11;
  wire            dual   = issue_op == 3'd7;
  wire            fire   = issue_valid && guard;

  assign gpr_rd_data = gpr_q[gpr_rd_addr];
  assign pred_rd_val = pred_q[pred_rd_idx];

  always_comb begin
    case (issue_cond)
      3'd0:    cond_res = opa == opb;
      3'd1:    cond_res = opa != opb;
      3'd2:    cond_res = $signed(opa) <  $signed(opb);
      3'd3:    cond_res = $signed(opa) <= $signed(opb);
      3'd4:    cond_res = $signed(opa) >  $signed(opb);
      3'd5:    cond_res = $signed(opa) >= $signed(opb);
      3'd6:    cond_res = opa <  opb;
      default: cond_res = opa >= opb;
    endcase
  end

  always_comb begin
    case (issue_op)
      3'd0:    alu_res = opa + opb;
      3'd1:    alu_res = opa - opb;
      3'd2:    alu_res = opa & opb;
      3'd3:    alu_res = opa | opb;
      3'd4:    alu_res = opa ^ opb;
      default: alu_res = opa;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gpr_q  <= '0;
      pred_q <= {{(NPRED-1){1'b0}}, 1'b1};
    end else begin
      if (gpr_wr_en) gpr_q[gpr_wr_addr] <= gpr_wr_data;
      if (pred_wr_en && pred_wr_idx != '0) pred_q[pred_wr_idx] <= pred_wr_val;
      if (fire && !is_cmp) gpr_q[issue_dst] <= alu_res;
      if (fire && is_cmp) begin
        if (issue_pd1 != '0) pred_q[issue_pd1] <= cond_res;
        if (dual && issue_pd2 != '0) pred_q[issue_pd2] <= !cond_res;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      retire_valid    <= 1'b0;
      retire_squashed <= 1'b0;
    end else begin
      retire_valid    <= issue_valid;
      retire_squashed <= issue_valid && !guard;
    end
  end

  assert_p0_true_R1: assert property (@(posedge clk) disable iff (!rst_n) pred_q[0]);

  assert_retire_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> retire_valid);
  assert_no_spurious_retire_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |=> !retire_valid && !retire_squashed);
  assert_squash_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && !guard |=> retire_squashed);

  assert_off_keeps_gpr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && !guard && !gpr_wr_en |=> $stable(gpr_q));
  assert_off_cmp_keeps_pred_R7: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && !guard && is_cmp && !pred_wr_en |=> $stable(pred_q));

  assert_dual_opposite_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire && dual && issue_pd1 != issue_pd2 && issue_pd1 != '0 && issue_pd2 != '0
    |=> pred_q[$past(issue_pd1)] != pred_q[$past(issue_pd2)]);
endmodule

// File: tb/pred_exec_unit_tb_top.sv
module pred_exec_unit_tb_top;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic issue_valid = 0;
  logic [2:0] issue_op = 0, issue_cond = 0;
  logic [2:0] issue_dst = 0, issue_src1 = 0, issue_src2 = 0;
  logic [3:0] issue_guard = 0, issue_pd1 = 0, issue_pd2 = 0;
  logic gpr_wr_en = 0; logic [2:0] gpr_wr_addr = 0; logic [15:0] gpr_wr_data = 0;
  logic [2:0] gpr_rd_addr = 0; logic [15:0] gpr_rd_data;
  logic pred_wr_en = 0; logic [3:0] pred_wr_idx = 0; logic pred_wr_val = 0;
  logic [3:0] pred_rd_idx = 0; logic pred_rd_val;
  logic retire_valid, retire_squashed;

  pred_exec_unit dut_i (.*);

  int checks = 0, fails = 0;
  logic [15:0] m_gpr [8];
  bit m_pred [16];

  function automatic logic [15:0] alu_f(int op, logic [15:0] a, logic [15:0] b);
    case (op)
      0: return a + b;   1: return a - b;   2: return a & b;
      3: return a | b;   4: return a ^ b;   default: return a;
    endcase
  endfunction

  function automatic bit cond_f(int c, logic [15:0] a, logic [15:0] b);
    case (c)
      0: return a == b;  1: return a != b;
      2: return $signed(a) <  $signed(b);  3: return $signed(a) <= $signed(b);
      4: return $signed(a) >  $signed(b);  5: return $signed(a) >= $signed(b);
      6: return a < b;   default: return a >= b;
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic scan_state(string req);
    int bad = 0, act = 0, exp = 0;
    for (int i = 0; i < 8; i++) begin
      gpr_rd_addr = 3'(i); #1;
      if (gpr_rd_data !== m_gpr[i]) begin bad++; act = gpr_rd_data; exp = m_gpr[i]; end
    end
    for (int i = 0; i < 16; i++) begin
      pred_rd_idx = 4'(i); #1;
      if (pred_rd_val !== m_pred[i]) begin bad++; act = pred_rd_val; exp = m_pred[i]; end
    end
    chk(bad == 0, req, act, exp);
  endtask

  task automatic side_gpr(int a, logic [15:0] d);
    @(negedge clk);
    gpr_wr_en = 1; gpr_wr_addr = 3'(a); gpr_wr_data = d;
    @(posedge clk); #1 gpr_wr_en = 0;
    m_gpr[a] = d;
  endtask

  task automatic side_pred(int a, bit v);
    @(negedge clk);
    pred_wr_en = 1; pred_wr_idx = 4'(a); pred_wr_val = v;
    @(posedge clk); #1 pred_wr_en = 0;
    if (a != 0) m_pred[a] = v;
  endtask

  task automatic do_op(int op, int cnd, int dst, int s1, int s2, int g, int p1, int p2, string req);
    bit gv, cv;
    logic [15:0] a, b;
    @(negedge clk);
    issue_valid = 1; issue_op = 3'(op); issue_cond = 3'(cnd);
    issue_dst = 3'(dst); issue_src1 = 3'(s1); issue_src2 = 3'(s2);
    issue_guard = 4'(g); issue_pd1 = 4'(p1); issue_pd2 = 4'(p2);
    gv = m_pred[g]; a = m_gpr[s1]; b = m_gpr[s2];
    cv = cond_f(cnd, a, b);
    @(posedge clk); #1 issue_valid = 0;
    chk(retire_valid === 1'b1 && retire_squashed === !gv, {req, " retire R8"},
        {retire_valid, retire_squashed}, {1'b1, !gv});
    if (gv) begin
      if (op < 6) m_gpr[dst] = alu_f(op, a, b);
      else begin
        if (p1 != 0) m_pred[p1] = cv;
        if (op == 7 && p2 != 0) m_pred[p2] = !cv;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2243));
    for (int i = 0; i < 8; i++) m_gpr[i] = 0;
    for (int i = 0; i < 16; i++) m_pred[i] = (i == 0);
    repeat (3) @(posedge clk);
    #1 scan_state("R2 reset state");
    chk(retire_valid === 0, "R8 no retire in reset", retire_valid, 0);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    chk(retire_valid === 0, "R8 idle no retire", retire_valid, 0);

    side_gpr(1, 16'hFFFF); side_gpr(2, 16'h0001); side_gpr(3, 16'h1234); side_gpr(4, 16'h00F0);
    scan_state("R9 side loads");

    for (int op = 0; op < 6; op++) begin
      do_op(op, 0, 5, 3, 4, 0, 0, 0, "R3 alu");
      gpr_rd_addr = 3'd5; #1;
      chk(gpr_rd_data === m_gpr[5], "R3 alu result", gpr_rd_data, m_gpr[5]);
    end
    do_op(0, 0, 6, 1, 2, 0, 0, 0, "R3 wrap");
    gpr_rd_addr = 3'd6; #1;
    chk(gpr_rd_data === 16'h0000, "R3 add wraps", gpr_rd_data, 0);

    side_pred(0, 0);
    pred_rd_idx = 0; #1;
    chk(pred_rd_val === 1'b1, "R1 side write to p0", pred_rd_val, 1);
    do_op(6, 6, 0, 2, 1, 0, 0, 0, "R1 cmp to p0");
    pred_rd_idx = 0; #1;
    chk(pred_rd_val === 1'b1, "R1 cmp to p0 ignored", pred_rd_val, 1);

    for (int c = 0; c < 8; c++) begin
      do_op(6, c, 0, 1, 2, 0, 3, 0, "R5 cmp");
      pred_rd_idx = 3; #1;
      chk(pred_rd_val === cond_f(c, 16'hFFFF, 16'h0001), "R5 cond -1 vs 1",
          pred_rd_val, cond_f(c, 16'hFFFF, 16'h0001));
      do_op(6, c, 0, 2, 2, 0, 3, 0, "R5 cmp eq");
      pred_rd_idx = 3; #1;
      chk(pred_rd_val === cond_f(c, 16'h1, 16'h1), "R5 cond equal", pred_rd_val, cond_f(c, 16'h1, 16'h1));
    end

    do_op(7, 2, 0, 1, 2, 0, 4, 5, "R6 dual");
    scan_state("R6 dual writes pair");
    do_op(5, 0, 7, 3, 0, 4, 0, 0, "R3 ifconv taken");
    do_op(5, 0, 7, 4, 0, 5, 0, 0, "R4 ifconv skipped");
    gpr_rd_addr = 3'd7; #1;
    chk(gpr_rd_data === 16'h1234, "R3 R4 if-conversion", gpr_rd_data, 16'h1234);
    do_op(7, 0, 0, 1, 1, 0, 6, 6, "R6 same index");
    pred_rd_idx = 6; #1;
    chk(pred_rd_val === 1'b0, "R6 complement wins", pred_rd_val, 0);

    do_op(0, 0, 1, 3, 3, 5, 0, 0, "R4 off add");
    scan_state("R4 off add no effect");
    do_op(7, 0, 0, 2, 2, 5, 8, 9, "R7 off cmp");
    scan_state("R7 off cmp no write");

    @(negedge clk);
    gpr_wr_en = 1; gpr_wr_addr = 3'd2; gpr_wr_data = 16'hBEEF;
    issue_valid = 1; issue_op = 3'd5; issue_dst = 3'd2; issue_src1 = 3'd3; issue_guard = 0;
    @(posedge clk); #1 gpr_wr_en = 0; issue_valid = 0;
    m_gpr[2] = 16'h1234;
    gpr_rd_addr = 3'd2; #1;
    chk(gpr_rd_data === 16'h1234, "R9 issue wins collision", gpr_rd_data, 16'h1234);

    for (int n = 0; n < 400; n++) begin
      int op, g;
      op = int'($urandom_range(0, 7));
      g = ($urandom_range(0, 3) == 0) ? 0 : int'($urandom_range(0, 15));
      if ($urandom_range(0, 9) == 0) side_pred(int'($urandom_range(1, 15)), 1'($urandom));
      if ($urandom_range(0, 9) == 0) side_gpr(int'($urandom_range(0, 7)), 16'($urandom));
      do_op(op, int'($urandom_range(0, 7)), int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
            int'($urandom_range(0, 7)), g, int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
            "R3 R4 R5 R6 R7 random");
      if (n % 8 == 7) scan_state("R3 R5 R6 random state");
    end
    scan_state("R1 R4 R7 final state");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule